// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets the cores of a multi-core cluster interrupt one another through a small register window. Every core owns a first-in first-out queue of pending interrupt numbers and one interrupt request line. Any core can post a number to one other core, or to every core but one, by writing a single word. The word holds the number in its upper half and a core index in its lower half. A receiving core takes its interrupts back one at a time by reading its receive register. The block uses the requester core ID that travels with each bus access to pick the queue.

The value 0 is kept to mean "nothing pending", so software must never send it. A write of any value to the receive register throws away everything still queued for the writer. When a queue is full, the block drops a new entry and latches a per-core overflow flag. Queue depth, core count and bus widths are parameters. All queues can accept an entry in the same cycle, which makes a broadcast a single-cycle operation.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset, every interrupt line is low, every overflow flag is low, `bus_rvalid` is low, and every queue is empty.
- R2: A write to word offset 0 appends `bus_wdata[31:16]` to the tail of the queue of the core indexed by `bus_wdata[15:0]`, and to no other queue. That core's `irq` bit is high from the clock edge that samples the write onward.
- R3: A write to word offset 1 appends `bus_wdata[31:16]` to the queue of every core whose index differs from `bus_wdata[15:0]`. All of these appends complete in the same cycle. If the index is not a valid core, every core receives the entry.
- R4: A read of word offset 2 returns the oldest entry of the queue of core `bus_core_id` on `bus_rdata[15:0]` and removes that entry. The upper bits read as zero. `bus_rvalid` and `bus_rdata` are registered and valid right after the edge that samples the read. Entries come out in the order they went in.
- R5: A read of word offset 2 with an empty queue returns 0 and changes no state.
- R6: A write of any value to word offset 2 empties the queue of core `bus_core_id`, and that core's `irq` bit is low after the edge.
- R7: A core's `irq` bit falls on the edge that removes the last entry of its queue. It stays high while any entry remains.
- R8: An append to a full queue is dropped, and the entries already queued stay intact. The core's `overflow` bit goes high and stays high until reset.
- R9: A word-offset-0 write whose index is not a valid core changes no queue and no interrupt line.
- R10: Writes to any word offset other than 0, 1 or 2 have no effect. Reads of such offsets return 0 with `bus_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_core_id | input | CID_W | Index of the requesting core |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| irq | output | NUM_CORES | Per-core interrupt request, high while its queue is non-empty |
| overflow | output | NUM_CORES | Per-core sticky flag for dropped entries |

## Verification
Every result of this block appears one clock edge after the access that causes it. Queue appends and flushes show on `irq` right after the edge that samples the write. Read data and `bus_rvalid` show right after the edge that samples the read. The drop of `irq` on the last pop also shows right after that edge, as does the overflow flag. The bench drives each access on the falling edge and checks all outputs one time unit after the next rising edge, so each check sees exactly the state that one access produced.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // Word offsets of the register window; software depends on these.
  localparam int OFS_SEND_ONE    = 0;
  localparam int OFS_SEND_OTHERS = 1;
  localparam int OFS_RECEIVE     = 2;
  // Low half of a send word holds the core index.
  localparam int TGT_W = 16;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CID_W     = 2,
  parameter int NUM_W     = DATA_W - ipi_pkg::TGT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [CID_W-1:0]     core_i,
  output logic [NUM_CORES-1:0] push_o,
  output logic [NUM_CORES-1:0] pop_o,
  output logic [NUM_CORES-1:0] flush_o,
  output logic [NUM_W-1:0]     num_o,
  output logic                 recv_rd_o
);
  import ipi_pkg::*;

  logic                 hit_one, hit_others, hit_recv;
  logic [TGT_W-1:0]     target;

  assign hit_one    = sel_i && we_i && (addr_i == ADDR_W'(OFS_SEND_ONE));
  assign hit_others = sel_i && we_i && (addr_i == ADDR_W'(OFS_SEND_OTHERS));
  assign hit_recv   = sel_i && (addr_i == ADDR_W'(OFS_RECEIVE));
  assign recv_rd_o  = hit_recv && !we_i;
  assign target     = wdata_i[TGT_W-1:0];
  assign num_o      = wdata_i[DATA_W-1:TGT_W];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assign push_o[g]  = (hit_one && (target == TGT_W'(g))) ||
                        (hit_others && (target != TGT_W'(g)));
    assign pop_o[g]   = hit_recv && !we_i && (core_i == CID_W'(g));
    assign flush_o[g] = hit_recv && we_i && (core_i == CID_W'(g));
  end

  // R2: a unicast send reaches at most one queue
  assert_unicast_single_R2: assert property (@(posedge clk) disable iff (rst)
    hit_one |-> $onehot0(push_o));
  // R3: a broadcast reaches at least all cores but one
  assert_broadcast_width_R3: assert property (@(posedge clk) disable iff (rst)
    hit_others |-> ($countones(push_o) >= NUM_CORES - 1));
endmodule

// File: rtl/ipi_queue.sv
module ipi_queue #(
  parameter int DEPTH = 4,
  parameter int NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [NUM_W-1:0] din_i,
  output logic [NUM_W-1:0] head_o,
  output logic             empty_o,
  output logic             irq_o,
  output logic             ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] count_q, count_d;
  logic             full, empty, do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_pop  = pop_i && !empty && !flush_i;
  assign do_push = push_i && !flush_i && (!full || do_pop);

  always_comb begin
    if (flush_i)
      count_d = '0;
    else
      count_d = count_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      irq_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (flush_i) begin
        rd_q <= wr_q;
      end else begin
        if (do_push) wr_q <= bump(wr_q);
        if (do_pop)  rd_q <= bump(rd_q);
      end
      count_q <= count_d;
      irq_o   <= (count_d != '0);
      if (push_i && !flush_i && !do_push) ovf_o <= 1'b1;
    end
  end

  // Storage without reset so that it maps onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  assign head_o  = mem[rd_q];
  assign empty_o = empty;

  assert_push_raises_irq_R2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !flush_i) |=> irq_o);
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!irq_o && count_q == '0));
  assert_last_pop_drops_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !flush_i && count_q == CNT_W'(1)) |=> !irq_o);
  assert_full_push_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (push_i && full && !pop_i && !flush_i) |=> (ovf_o && count_q == CNT_W'(DEPTH)));
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int NUM_CORES = 4,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [CID_W-1:0]     bus_core_id,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CORES-1:0] irq,
  output logic [NUM_CORES-1:0] overflow
);
  localparam int NUM_W = DATA_W - ipi_pkg::TGT_W;

  logic [NUM_CORES-1:0] push, pop, flush, empty;
  logic [NUM_W-1:0]     num;
  logic [NUM_W-1:0]     head [NUM_CORES];
  logic [NUM_W-1:0]     rd_sel;
  logic                 recv_rd;

  ipi_decode #(
    .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CID_W(CID_W), .NUM_W(NUM_W)
  ) decode_i (
    .clk(clk), .rst(rst),
    .sel_i(bus_sel), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .core_i(bus_core_id),
    .push_o(push), .pop_o(pop), .flush_o(flush),
    .num_o(num), .recv_rd_o(recv_rd)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_queue
    ipi_queue #(.DEPTH(DEPTH), .NUM_W(NUM_W)) queue_i (
      .clk(clk), .rst(rst),
      .push_i(push[g]), .pop_i(pop[g]), .flush_i(flush[g]),
      .din_i(num), .head_o(head[g]), .empty_o(empty[g]),
      .irq_o(irq[g]), .ovf_o(overflow[g])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (pop[c] && !empty[c]) rd_sel = head[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_sel && !bus_we;
      bus_rdata  <= {{(DATA_W - NUM_W){1'b0}}, recv_rd ? rd_sel : NUM_W'(0)};
    end
  end

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);
  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (recv_rd && ((pop & ~empty) == '0)) |=> (bus_rdata == '0));
  assert_write_no_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel || bus_we) |=> !bus_rvalid);
endmodule

// File: tb/ipi_mailbox_tb_top.sv
module ipi_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_core_id = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NC-1:0] irq, overflow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_mailbox dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core_id(bus_core_id),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq), .overflow(overflow)
  );

  // {req, we, addr, core, wdata, expected rdata, expected irq}
  localparam int NV = 18;
  localparam logic [62:0] VEC [NV] = '{
    {4'd2,  1'b1, 4'd0, 2'd0, 32'h0005_0002, 16'h0, 4'b0100}, // R2 unicast to core 2
    {4'd2,  1'b1, 4'd0, 2'd0, 32'h0007_0002, 16'h0, 4'b0100}, // R2 second entry
    {4'd3,  1'b1, 4'd1, 2'd1, 32'h0009_0001, 16'h0, 4'b1101}, // R3 all but core 1
    {4'd4,  1'b0, 4'd2, 2'd2, 32'h0,         16'h5, 4'b1101}, // R4 oldest first
    {4'd4,  1'b0, 4'd2, 2'd2, 32'h0,         16'h7, 4'b1101}, // R4 order
    {4'd7,  1'b0, 4'd2, 2'd2, 32'h0,         16'h9, 4'b1001}, // R7 last pop drops irq
    {4'd5,  1'b0, 4'd2, 2'd2, 32'h0,         16'h0, 4'b1001}, // R5 empty reads 0
    {4'd4,  1'b0, 4'd2, 2'd0, 32'h0,         16'h9, 4'b1000}, // R4 core 0 queue
    {4'd6,  1'b1, 4'd2, 2'd3, 32'hDEAD_BEEF, 16'h0, 4'b0000}, // R6 flush core 3
    {4'd6,  1'b0, 4'd2, 2'd3, 32'h0,         16'h0, 4'b0000}, // R6 flushed queue empty
    {4'd9,  1'b1, 4'd0, 2'd0, 32'h0003_0007, 16'h0, 4'b0000}, // R9 bad target
    {4'd3,  1'b1, 4'd1, 2'd2, 32'h0004_FFFF, 16'h0, 4'b1111}, // R3 bad index hits all
    {4'd10, 1'b1, 4'd5, 2'd0, 32'h0006_0000, 16'h0, 4'b1111}, // R10 unused offset write
    {4'd10, 1'b0, 4'd5, 2'd1, 32'h0,         16'h0, 4'b1111}, // R10 unused offset read
    {4'd10, 1'b0, 4'd2, 2'd0, 32'h0,         16'h4, 4'b1110}, // R10 value 6 not queued
    {4'd4,  1'b0, 4'd2, 2'd1, 32'h0,         16'h4, 4'b1100}, // R4
    {4'd4,  1'b0, 4'd2, 2'd2, 32'h0,         16'h4, 4'b1000}, // R4
    {4'd4,  1'b0, 4'd2, 2'd3, 32'h0,         16'h4, 4'b0000}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] addr,
                        input logic [1:0] core, input logic [31:0] wd);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = addr;
    bus_core_id = core; bus_wdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  string tag;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state (rst still high)
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 overflow", 32'(overflow), 32'h0);
    chk("R1 rvalid", 32'(bus_rvalid), 32'h0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[62:59], i);
      access(v[58], v[57:54], v[53:52], v[51:20]);
      chk({tag, " rvalid"}, 32'(bus_rvalid), 32'(!v[58]));
      if (!v[58]) chk({tag, " rdata"}, bus_rdata, {16'h0, v[19:4]});
      chk({tag, " irq"}, 32'(irq), 32'(v[3:0]));
    end
    idle();
    chk("R1 overflow still clear", 32'(overflow), 32'h0);

    // R8 fill core 1 beyond depth 4
    for (int k = 1; k <= 5; k++) begin
      access(1'b1, 4'd0, 2'd0, {16'(k), 16'd1});
      chk("R2 irq core1", 32'(irq), 32'h2);
    end
    chk("R8 overflow set", 32'(overflow), 32'h2);
    for (int k = 1; k <= 4; k++) begin
      access(1'b0, 4'd2, 2'd1, 32'h0);
      chk("R8 kept entry", bus_rdata, 32'(k));
      chk("R7 irq while pending", 32'(irq), (k < 4) ? 32'h2 : 32'h0);
    end
    access(1'b0, 4'd2, 2'd1, 32'h0);
    chk("R8 dropped entry absent", bus_rdata, 32'h0);
    chk("R8 overflow sticky", 32'(overflow), 32'h2);
    idle();

    // R1 reset clears queued state
    access(1'b1, 4'd1, 2'd0, 32'h000A_0000);
    chk("R3 irq", 32'(irq), 32'hE);
    @(negedge clk) begin rst = 1'b1; bus_sel = 1'b0; end
    @(posedge clk); #1;
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 overflow after reset", 32'(overflow), 32'h0);
    access(1'b0, 4'd2, 2'd2, 32'h0);
    chk("R1 queue empty after reset", bus_rdata, 32'h0);
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule